// File: doc/BRIEF.md
# Cascaded 16-bit Match-Clear Timer

This block joins two 8-bit timer halves into a single 16-bit up-counter. The low half holds the low byte of both the counter and the 16-bit compare value, and the high half holds the high byte. The halves act as one counter only while the high half's control register selects the joined mode. The counter then advances on one of two sources. The first is a prescaled copy of the system clock, with a ratio picked from 2, 4, 8, 32, 128, 512 or 2048. The second is a synchronized rising edge on an external clock pin.

On a count step where the counter already equals the compare value, the counter returns to zero and raises an interrupt request. The request stays high until the interrupt controller pulses an acknowledge. Software reaches the block through a byte-wide register port. It writes two control registers and the two compare bytes, and it reads them back together with the two live counter bytes. In the low control register, a start bit holds the counter at zero and a continue bit pauses it.

Top module: `cascade_match_timer`

## Requirements
- R1: After reset, every register reads 0x00, the counter reads 0x0000 and `irq` is low.
- R2: The low control register's clock select field is bits 4:2. Codes 000, 001, 010, 011, 100, 101 and 110 advance the counter once every 2, 4, 8, 32, 128, 512 and 2048 system clocks. Counting starts from the write that sets the run bits, and the first step comes a full period after that write.
- R3: Clock select code 111 counts the external pin. Each rising edge of `ext_clk` gives exactly one step after a two-flop synchronizer, with a latency of three clocks.
- R4: Each step raises the counter by one. A step taken while the counter equals the compare value returns the counter to 0x0000, so the counter repeats with a period of compare value plus one steps.
- R5: The step that returns the counter to zero sets `irq` on the following clock. `irq` then stays high until a cycle with `irq_ack` high and no match, and it reads low one clock after that cycle.
- R6: When `irq_ack` and a match occur in the same cycle, `irq` stays high.
- R7: The counter advances only when the high control register has bit 7 set and its bits 3:0 equal 1111. With any other value the counter holds.
- R8: Low control bit 0 is start and bit 1 is continue. Start at 0 forces the counter to 0x0000. Start at 1 with continue at 0 freezes the counter at its current value, and setting continue again resumes counting from that value.
- R9: The register map is as follows. Address 0 is low control and address 1 is high control. Address 2 is the compare low byte and address 3 is the compare high byte. Address 4 reads the counter low byte and address 5 reads the counter high byte. Every other address reads 0x00. Compare writes take effect on the next clock.
- R10: Low control bit 7 enables the prescaler. While it is 0, the prescaled clock selects never step the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Register write byte |
| rd_data | output | 8 | Register read byte (combinational) |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request flag |

## Verification
A wrong step count or a skipped prescaler tick shows up in the counter bytes after the very next period of the selected ratio. The bench therefore reads the counter after an exact number of clocks instead of accepting a range. A flaw in the compare or clear path shows up at `irq` and at the counter bytes one clock after the compare step. A wrong priority between acknowledge and a new match stays hidden until the two coincide, so the bench forces them into the same clock.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int HALF_W = 8;
  localparam int ADDR_W = 3;

  // low control bit positions
  localparam int EN_BIT    = 7;
  localparam int START_BIT = 0;
  localparam int CONT_BIT  = 1;
  localparam int SEL_LSB   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTL_LO = 3'd0,
    A_CTL_HI = 3'd1,
    A_DAT_LO = 3'd2,
    A_DAT_HI = 3'd3,
    A_CNT_LO = 3'd4,
    A_CNT_HI = 3'd5
  } reg_addr_e;

  localparam logic [2:0] SEL_EXT = 3'b111;

  // log2 of the division ratio for a prescaled select code
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 7;
      3'd5:    return 9;
      default: return 11;
    endcase
  endfunction

  // joined 16-bit mode decode of the high control byte
  function automatic logic cascade_on(input logic [7:0] ctl_hi);
    return ctl_hi[7] && (ctl_hi[3:0] == 4'hF);
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int PRE_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  import cmt_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'((1 << div_shift(sel)) - 1);
    tick = en && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (!en) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cmt_edge_sync.sv
module cmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cmt_core.sv
module cmt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] data,
  input  logic             ack,
  output logic [CNT_W-1:0] cnt,
  output logic             match,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  assign match = step && (cnt_q == data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (match) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (match) irq_q <= 1'b1;
    else if (ack)   irq_q <= 1'b0;
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/cascade_match_timer.sv
module cascade_match_timer #(
  parameter int HALF_W      = 8,
  parameter int PRE_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [cmt_pkg::ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0]          wr_data,
  output logic [HALF_W-1:0]          rd_data,
  input  logic                       ext_clk,
  input  logic                       irq_ack,
  output logic                       irq
);
  import cmt_pkg::*;

  localparam int HALVES = 2;
  localparam int CNT_W  = HALVES * HALF_W;

  logic [HALF_W-1:0] ctl_lo_q, ctl_hi_q;
  logic [CNT_W-1:0]  dat_q;
  logic [CNT_W-1:0]  cnt_w;

  // named internal events
  logic       run_w, ext_sel_w, pre_en_w, pre_tick_w, ext_rise_w;
  logic       step_ev, match_ev, clear_w;
  logic [2:0] sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_lo_q <= '0;
      ctl_hi_q <= '0;
      dat_q    <= '0;
    end else if (wr_en) begin
      if (addr == A_CTL_LO) ctl_lo_q <= wr_data;
      if (addr == A_CTL_HI) ctl_hi_q <= wr_data;
      for (int h = 0; h < HALVES; h++) begin
        if (addr == ADDR_W'(32'(A_DAT_LO) + h))
          dat_q[h*HALF_W +: HALF_W] <= wr_data;
      end
    end
  end

  always_comb begin
    sel_w     = ctl_lo_q[SEL_LSB +: 3];
    ext_sel_w = (sel_w == SEL_EXT);
    clear_w   = !ctl_lo_q[START_BIT];
    run_w     = ctl_lo_q[START_BIT] && ctl_lo_q[CONT_BIT] && cascade_on(ctl_hi_q);
    pre_en_w  = ctl_lo_q[EN_BIT] && run_w && !ext_sel_w;
    step_ev   = run_w && (ext_sel_w ? ext_rise_w : pre_tick_w);
  end

  cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(pre_en_w), .sel(sel_w), .tick(pre_tick_w)
  );

  cmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(ext_rise_w)
  );

  cmt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(clear_w), .step(step_ev),
    .data(dat_q), .ack(irq_ack), .cnt(cnt_w), .match(match_ev), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTL_LO: rd_data = ctl_lo_q;
      A_CTL_HI: rd_data = ctl_hi_q;
      A_DAT_LO: rd_data = dat_q[0 +: HALF_W];
      A_DAT_HI: rd_data = dat_q[HALF_W +: HALF_W];
      A_CNT_LO: rd_data = cnt_w[0 +: HALF_W];
      A_CNT_HI: rd_data = cnt_w[HALF_W +: HALF_W];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             step,
  input logic             match,
  input logic             start,
  input logic             irq,
  input logic             irq_ack
);
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt == '0));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (start && step && !match) |=> (cnt == $past(cnt) + 1'b1));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !step) |=> $stable(cnt));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cnt == '0));

  // R5 and R6: a match sets the flag whatever irq_ack does
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq);

  a_r5_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !match) |=> !irq);

  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
endmodule

bind cascade_match_timer cmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .step(step_ev), .match(match_ev),
  .start(ctl_lo_q[0]), .irq(irq), .irq_ack(irq_ack)
);

// File: tb/sim_cascade_match_timer.sv
`timescale 1ns/1ps
module sim_cascade_match_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       ext_clk = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cascade_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ext_clk(ext_clk), .irq_ack(irq_ack), .irq(irq)
  );

  function automatic int ratio(input int sel);
    int r;
    r = (sel == 0) ? 2 : (sel == 1) ? 4 : (sel == 2) ? 8 : (sel == 3) ? 32 :
        (sel == 4) ? 128 : (sel == 5) ? 512 : 2048;
    return r;
  endfunction

  function automatic logic [7:0] ctl_word(input bit en, input int sel, input bit cont, input bit start);
    return {en, 2'b00, sel[2:0], cont, start};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #0.1 d = rd_data;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd4, lo);
    rd(3'd5, hi);
    v = {hi, lo};
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // stop, load compare value and mode, then start: the start write is cycle zero
  task automatic arm(input bit en, input int sel, input logic [15:0] dat, input logic [7:0] hi);
    wr(3'd0, 8'h00);
    wr(3'd2, dat[7:0]);
    wr(3'd3, dat[15:8]);
    wr(3'd1, hi);
    wr(3'd0, ctl_word(en, sel, 1'b1, 1'b1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    int          s, m, d;
    s = $urandom(32'd1791);

    #9 rst_n = 1'b1;
    cycles(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], b);
      chk("R1 reg", {8'h00, b}, 16'h0000);
    end
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R9 register map readback and unused address
    wr(3'd2, 8'hA5); wr(3'd3, 8'h3C); wr(3'd1, 8'h8F); wr(3'd6, 8'hFF);
    rd(3'd2, b); chk("R9 dat lo", {8'h00, b}, 16'h00A5);
    rd(3'd3, b); chk("R9 dat hi", {8'h00, b}, 16'h003C);
    rd(3'd1, b); chk("R9 ctl hi", {8'h00, b}, 16'h008F);
    rd(3'd6, b); chk("R9 unused", {8'h00, b}, 16'h0000);

    // R2 every prescaled ratio, directed
    for (int sel = 0; sel < 7; sel++) begin
      arm(1'b1, sel, 16'hFFFF, 8'h8F);
      cycles(3 * ratio(sel));
      rd_cnt(v);
      chk("R2 ratio", v, 16'd3);
    end

    // R2 random ratios and lengths
    for (int i = 0; i < 8; i++) begin
      s = $urandom_range(6, 0);
      m = $urandom_range(2, 1);
      arm(1'b1, s, 16'hFFFF, 8'h8F);
      cycles(m * ratio(s));
      rd_cnt(v);
      chk("R2 random", v, m[15:0]);
    end

    // R4 R5 R6 wrap, flag, acknowledge priority with random compare values
    for (int i = 0; i < 6; i++) begin
      s = $urandom_range(2, 0);
      d = $urandom_range(30, 2);
      arm(1'b1, s, d[15:0], 8'h8F);
      cycles(d * ratio(s));
      rd_cnt(v);
      chk("R4 at compare", v, d[15:0]);
      chk("R5 not yet", {15'd0, irq}, 16'd0);
      cycles(ratio(s));
      rd_cnt(v);
      chk("R4 wrap", v, 16'd0);
      chk("R5 set", {15'd0, irq}, 16'd1);
      cycles(d * ratio(s) + ratio(s) - 1);
      irq_ack = 1'b1;
      cycles(1);
      irq_ack = 1'b0;
      chk("R6 ack with match", {15'd0, irq}, 16'd1);
      cycles(1);
      irq_ack = 1'b1;
      cycles(1);
      irq_ack = 1'b0;
      chk("R5 ack clears", {15'd0, irq}, 16'd0);
    end

    // R9 byte order of counter
    arm(1'b1, 0, 16'h0105, 8'h8F);
    cycles(2 * 16'h0103);
    rd_cnt(v);
    chk("R9 byte order", v, 16'h0103);

    // R8 pause and resume
    arm(1'b1, 0, 16'hFFFF, 8'h8F);
    cycles(20);
    wr(3'd0, ctl_word(1'b1, 0, 1'b0, 1'b1));
    cycles(30);
    rd_cnt(v);
    chk("R8 paused", v, 16'd10);
    wr(3'd0, ctl_word(1'b1, 0, 1'b1, 1'b1));
    cycles(4);
    rd_cnt(v);
    chk("R8 resumed", v, 16'd12);
    wr(3'd0, ctl_word(1'b1, 0, 1'b1, 1'b0));
    cycles(1);
    rd_cnt(v);
    chk("R8 start clear", v, 16'd0);
    cycles(20);
    rd_cnt(v);
    chk("R8 start holds zero", v, 16'd0);

    // R7 joined mode decode
    arm(1'b1, 0, 16'hFFFF, 8'h8E);
    cycles(40);
    rd_cnt(v);
    chk("R7 field not 1111", v, 16'd0);
    arm(1'b1, 0, 16'hFFFF, 8'h0F);
    cycles(40);
    rd_cnt(v);
    chk("R7 bit7 clear", v, 16'd0);

    // R10 prescaler enable
    arm(1'b0, 0, 16'hFFFF, 8'h8F);
    cycles(40);
    rd_cnt(v);
    chk("R10 disabled", v, 16'd0);

    // R3 external clock pulses
    arm(1'b1, 7, 16'hFFFF, 8'h8F);
    m = $urandom_range(9, 4);
    for (int p = 0; p < m; p++) begin
      ext_clk = 1'b1; cycles(3);
      ext_clk = 1'b0; cycles(3);
    end
    cycles(4);
    rd_cnt(v);
    chk("R3 edges counted", v, m[15:0]);
    ext_clk = 1'b1; cycles(2);
    rd_cnt(v);
    chk("R3 latency before", v, m[15:0]);
    cycles(1);
    rd_cnt(v);
    chk("R3 latency after", v, m[15:0] + 16'd1);
    ext_clk = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule